// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the read lookup path of a set-associative data cache whose set is chosen only by bits that address translation leaves unchanged. A request carries a 24-bit virtual address. On the request's clock edge, two things happen together. The tag, valid and data arrays are read at the set named by the page-offset bits. A small fully associative translation buffer matches the virtual page number and captures the physical page number it maps to. In the next cycle, each way's stored physical tag is compared with the translated page number, and the matching way's word is returned.

The index and the line offset together fit inside the 12-bit page offset, so no translated bit chooses the set. Capacity therefore comes from associativity: 64 sets of 16 ways with 64-byte lines, which is 64 KB. Two virtual pages that map to one physical page always land in the same set and compare against the same physical tag, so they share a single copy of the line.

The translation buffer is loaded through a fill port. A new page takes the next slot in rotation, and a page that is already present is rewritten where it sits. Lines and their physical tags are installed through a line fill port. Page walks and refills from memory happen outside the block.

Top module: `vipt_cache`

## Requirements
- R1: After reset no response is flagged, every translation entry is empty and every cache line is invalid. A lookup then reports a translation miss, or a cache miss once the page is mapped.
- R2: The set is virtual address bits [11:6] and the 32-bit word within the line is bits [5:2]. Bits [1:0] and the page number bits take no part in choosing the set or the word.
- R3: A lookup hits when the translation buffer holds the page number and a valid way in the set stores the physical page number that the page translates to.
- R4: `resp_valid` is high exactly in the cycle after a cycle with `req` high, and the results are presented in that same cycle.
- R5: When the page number is not in the translation buffer, `tlb_miss` is high and `hit`, `miss` and `hit_way` are all low, even if a way's stored tag equals the value a missing translation would leave behind.
- R6: On a hit, `hit_way` has exactly one bit set, at bit position equal to the way number. `rdata` is that way's addressed word.
- R7: Two virtual pages mapped to the same physical page, accessed with the same offset, hit the same way and return the same data.
- R8: A fill of a page number not yet present writes the translation slot under a rotating pointer and advances the pointer by one modulo 16. The seventeenth such fill evicts the first entry.
- R9: A fill of a page number already present rewrites that entry in place and leaves the rotating pointer unchanged.
- R10: A translated lookup with no valid way holding a matching tag reports `miss` high, with `hit_way` zero and `rdata` zero.
- R11: A line fill sets the valid bit of the given set and way and replaces both its physical tag and its 512-bit data. Word k of the line occupies bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read lookup request |
| vaddr | input | 24 | Virtual byte address of the request |
| tlb_fill_en | input | 1 | Write a translation entry |
| tlb_fill_vpn | input | 12 | Virtual page number to install |
| tlb_fill_ppn | input | 12 | Physical page number it maps to |
| line_fill_en | input | 1 | Install a cache line |
| line_fill_set | input | 6 | Set to write |
| line_fill_way | input | 4 | Way to write |
| line_fill_ptag | input | 12 | Physical page tag for the line |
| line_fill_data | input | 512 | Line contents, word k at bits [32k+31:32k] |
| resp_valid | output | 1 | Results below belong to the previous cycle's request |
| hit | output | 1 | Translated and tag matched |
| miss | output | 1 | Translated but no way matched |
| tlb_miss | output | 1 | Page number not found in the translation buffer |
| hit_way | output | 16 | One-hot matching way |
| rdata | output | 32 | Addressed word of the hit way, zero otherwise |

## Verification
All results of a lookup are due one cycle after the cycle in which `req` is high. The bench raises `req` for one cycle at a falling edge and samples every output at the next falling edge, half a cycle after the capturing edge. At that point it also confirms that `resp_valid` was set by that request alone. Translation and line fills take effect at the rising edge after they are driven, so the bench completes each fill cycle before issuing a lookup that depends on it. The sweep covers every set and word for three mapped pages, two of which alias the same physical page.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned VA_W_DEF        = 24;
  localparam int unsigned PA_W_DEF        = 24;
  localparam int unsigned PAGE_BITS_DEF   = 12;
  localparam int unsigned LINE_BITS_DEF   = 6;
  localparam int unsigned WAYS_DEF        = 16;
  localparam int unsigned TLB_ENTRIES_DEF = 16;
  localparam int unsigned WORD_W_DEF      = 32;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int unsigned VPN_W   = 12,
  parameter int unsigned PPN_W   = 12,
  parameter int unsigned ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic               fill_present;
  logic [IDX_W-1:0]   fill_slot;
  logic [IDX_W-1:0]   victim;

  function automatic logic [IDX_W-1:0] first_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e]   = ent_valid[e] && (ent_vpn[e] == lk_vpn);
    assign fill_match[e] = ent_valid[e] && (ent_vpn[e] == fill_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) lk_ppn = lk_ppn | ent_ppn[e];
    end
  end

  assign lk_hit       = |lk_match;
  assign fill_present = |fill_match;
  assign fill_slot    = first_set(fill_match);
  assign victim       = fill_present ? fill_slot : rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (fill_en) begin
      ent_valid[victim] <= 1'b1;
      if (!fill_present) begin
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_vpn[victim] <= fill_vpn;
      ent_ppn[victim] <= fill_ppn;
    end
  end

  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_ptr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_present) |=> $stable(rr_ptr));
  p_ptr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_present) |=> (rr_ptr != $past(rr_ptr)));
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int unsigned SET_BITS = 6,
  parameter int unsigned WAYS     = 16,
  parameter int unsigned PPN_W    = 12,
  parameter int unsigned LINE_W   = 512,
  parameter int unsigned WORD_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [SET_BITS-1:0]           rd_set,
  input  logic [$clog2(LINE_W/WORD_W)-1:0] rd_word,
  input  logic                          wr_en,
  input  logic [SET_BITS-1:0]           wr_set,
  input  logic [$clog2(WAYS)-1:0]       wr_way,
  input  logic [PPN_W-1:0]              wr_tag,
  input  logic [LINE_W-1:0]             wr_line,
  output logic [WAYS-1:0]               q_valid,
  output logic [WAYS-1:0][PPN_W-1:0]    q_tag,
  output logic [WAYS-1:0][WORD_W-1:0]   q_word
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [WAYS-1:0]   vld_mem [SETS];
  logic [PPN_W-1:0]  tag_mem [SETS][WAYS];
  logic [LINE_W-1:0] dat_mem [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
      q_valid <= '0;
    end else begin
      if (wr_en) vld_mem[wr_set][wr_way] <= 1'b1;
      if (rd_en) q_valid <= vld_mem[rd_set];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set][wr_way] <= wr_tag;
      dat_mem[wr_set][wr_way] <= wr_line;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd_en) begin
        q_tag[w]  <= tag_mem[rd_set][w];
        q_word[w] <= dat_mem[rd_set][w][rd_word*WORD_W +: WORD_W];
      end
    end
  end

  p_fill_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_mem[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned PPN_W  = 12,
  parameter int unsigned WORD_W = 32
) (
  input  logic                        xlate_ok,
  input  logic [PPN_W-1:0]            xlate_ppn,
  input  logic [WAYS-1:0]             line_valid,
  input  logic [WAYS-1:0][PPN_W-1:0]  line_tag,
  input  logic [WAYS-1:0][WORD_W-1:0] line_word,
  output logic [WAYS-1:0]             way_hit,
  output logic [WORD_W-1:0]           hit_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = xlate_ok && line_valid[w] && (line_tag[w] == xlate_ppn);
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_data = hit_data | line_word[w];
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W        = VA_W_DEF,
  parameter int unsigned PA_W        = PA_W_DEF,
  parameter int unsigned PAGE_BITS   = PAGE_BITS_DEF,
  parameter int unsigned LINE_BITS   = LINE_BITS_DEF,
  parameter int unsigned WAYS        = WAYS_DEF,
  parameter int unsigned TLB_ENTRIES = TLB_ENTRIES_DEF,
  parameter int unsigned WORD_W      = WORD_W_DEF,
  localparam int unsigned SET_BITS   = PAGE_BITS - LINE_BITS,
  localparam int unsigned VPN_W      = VA_W - PAGE_BITS,
  localparam int unsigned PPN_W      = PA_W - PAGE_BITS,
  localparam int unsigned LINE_W     = (1 << LINE_BITS) * 8,
  localparam int unsigned BYTE_BITS  = $clog2(WORD_W / 8),
  localparam int unsigned WSEL_W     = LINE_BITS - BYTE_BITS,
  localparam int unsigned WAY_W      = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [VA_W-1:0]     vaddr,
  input  logic                tlb_fill_en,
  input  logic [VPN_W-1:0]    tlb_fill_vpn,
  input  logic [PPN_W-1:0]    tlb_fill_ppn,
  input  logic                line_fill_en,
  input  logic [SET_BITS-1:0] line_fill_set,
  input  logic [WAY_W-1:0]    line_fill_way,
  input  logic [PPN_W-1:0]    line_fill_ptag,
  input  logic [LINE_W-1:0]   line_fill_data,
  output logic                resp_valid,
  output logic                hit,
  output logic                miss,
  output logic                tlb_miss,
  output logic [WAYS-1:0]     hit_way,
  output logic [WORD_W-1:0]   rdata
);
  function automatic logic [SET_BITS-1:0] set_of(input logic [VA_W-1:0] va);
    return va[PAGE_BITS-1:LINE_BITS];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [VA_W-1:0] va);
    return va[LINE_BITS-1:BYTE_BITS];
  endfunction

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_BITS];
  endfunction

  logic                        unused_byte_bits;
  logic                        lk_hit;
  logic [PPN_W-1:0]            lk_ppn;
  logic                        req_q;
  logic                        tlb_hit_q;
  logic [PPN_W-1:0]            ppn_q;
  logic                        xlate_ok;
  logic [WAYS-1:0]             q_valid;
  logic [WAYS-1:0][PPN_W-1:0]  q_tag;
  logic [WAYS-1:0][WORD_W-1:0] q_word;
  logic [WAYS-1:0]             way_hit;
  logic [WORD_W-1:0]           hit_data;

  assign unused_byte_bits = ^vaddr[BYTE_BITS-1:0];

  vipt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (vpn_of(vaddr)),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .fill_en  (tlb_fill_en),
    .fill_vpn (tlb_fill_vpn),
    .fill_ppn (tlb_fill_ppn)
  );

  vipt_line_store #(
    .SET_BITS(SET_BITS), .WAYS(WAYS), .PPN_W(PPN_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (req),
    .rd_set  (set_of(vaddr)),
    .rd_word (word_of(vaddr)),
    .wr_en   (line_fill_en),
    .wr_set  (line_fill_set),
    .wr_way  (line_fill_way),
    .wr_tag  (line_fill_ptag),
    .wr_line (line_fill_data),
    .q_valid (q_valid),
    .q_tag   (q_tag),
    .q_word  (q_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      tlb_hit_q <= 1'b0;
      ppn_q     <= '0;
    end else begin
      req_q <= req;
      if (req) begin
        tlb_hit_q <= lk_hit;
        ppn_q     <= lk_ppn;
      end
    end
  end

  assign xlate_ok = req_q && tlb_hit_q;

  vipt_way_match #(.WAYS(WAYS), .PPN_W(PPN_W), .WORD_W(WORD_W)) u_match (
    .xlate_ok   (xlate_ok),
    .xlate_ppn  (ppn_q),
    .line_valid (q_valid),
    .line_tag   (q_tag),
    .line_word  (q_word),
    .way_hit    (way_hit),
    .hit_data   (hit_data)
  );

  assign resp_valid = req_q;
  assign tlb_miss   = req_q && !tlb_hit_q;
  assign hit_way    = way_hit;
  assign hit        = |way_hit;
  assign miss       = xlate_ok && !hit;
  assign rdata      = hit_data;

  p_resp_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req));
  p_no_hit_untranslated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_miss |-> (!hit && !miss && hit_way == '0));
  p_way_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_way));
  p_hit_has_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (resp_valid && $countones(hit_way) == 1));
  p_miss_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit_way == '0 && rdata == '0 && !tlb_miss));
endmodule

// File: tb/vipt_cache_test.sv
`timescale 1ns/1ps
module vipt_cache_test;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [23:0]   vaddr = '0;
  logic          tlb_fill_en = 1'b0;
  logic [11:0]   tlb_fill_vpn = '0;
  logic [11:0]   tlb_fill_ppn = '0;
  logic          line_fill_en = 1'b0;
  logic [5:0]    line_fill_set = '0;
  logic [3:0]    line_fill_way = '0;
  logic [11:0]   line_fill_ptag = '0;
  logic [511:0]  line_fill_data = '0;
  logic          resp_valid, hit, miss, tlb_miss;
  logic [15:0]   hit_way;
  logic [31:0]   rdata;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  vipt_cache uut (
    .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr),
    .tlb_fill_en(tlb_fill_en), .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
    .line_fill_en(line_fill_en), .line_fill_set(line_fill_set), .line_fill_way(line_fill_way),
    .line_fill_ptag(line_fill_ptag), .line_fill_data(line_fill_data),
    .resp_valid(resp_valid), .hit(hit), .miss(miss), .tlb_miss(tlb_miss),
    .hit_way(hit_way), .rdata(rdata)
  );

  function automatic logic [31:0] ew(input bit alt, input logic [11:0] ptag,
                                     input logic [5:0] s, input logic [3:0] w);
    return {alt ? 2'b01 : 2'b10, ptag, s, w, 8'h5C};
  endfunction

  function automatic logic [51:0] exp_hit(input int way, input logic [31:0] d);
    return {4'b1100, 16'(1 << way), d};
  endfunction

  localparam logic [51:0] EXP_MISS = {4'b1010, 16'h0, 32'h0};
  localparam logic [51:0] EXP_TLBM = {4'b1001, 16'h0, 32'h0};

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tlb_fill(input logic [11:0] vpn, input logic [11:0] ppn);
    @(negedge clk);
    tlb_fill_en = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
    @(negedge clk);
    tlb_fill_en = 1'b0;
  endtask

  task automatic line_fill(input logic [5:0] s, input logic [3:0] way,
                           input logic [11:0] ptag, input bit alt);
    @(negedge clk);
    line_fill_en = 1'b1; line_fill_set = s; line_fill_way = way; line_fill_ptag = ptag;
    for (int w = 0; w < 16; w++) line_fill_data[w*32 +: 32] = ew(alt, ptag, s, 4'(w));
    @(negedge clk);
    line_fill_en = 1'b0;
  endtask

  task automatic look(input string rq, input logic [11:0] vpn, input logic [5:0] s,
                      input logic [3:0] w, input logic [51:0] exp);
    @(negedge clk);
    req = 1'b1; vaddr = {vpn, s, w, 2'b11};
    @(negedge clk);
    req = 1'b0;
    chk(rq, {12'h0, resp_valid, hit, miss, tlb_miss, hit_way, rdata}, {12'h0, exp});
    @(negedge clk);
    chk("R4 single response", {63'h0, resp_valid}, 64'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk("R1 reset outputs", {12'h0, resp_valid, hit, miss, tlb_miss, hit_way, rdata}, 64'h0);
    look("R1 empty translation", 12'h010, 6'd5, 4'd2, EXP_TLBM);

    tlb_fill(12'h010, 12'h3A0);   // slot 0
    tlb_fill(12'h020, 12'h3A0);   // slot 1, alias of the same physical page
    tlb_fill(12'h030, 12'h155);   // slot 2
    tlb_fill(12'h050, 12'h777);   // slot 3
    look("R1 lines invalid after reset", 12'h010, 6'd5, 4'd2, EXP_MISS);

    for (int s = 0; s < 64; s++) begin
      line_fill(6'(s), 4'(s % 16), 12'h3A0, 1'b0);
      line_fill(6'(s), 4'((s + 5) % 16), 12'h155, 1'b0);
    end

    // R2 R3 R6 R7: sweep all sets and words
    for (int s = 0; s < 64; s++) begin
      for (int w = 0; w < 16; w++) begin
        look("R3 R6 translated hit", 12'h010, 6'(s), 4'(w),
             exp_hit(s % 16, ew(1'b0, 12'h3A0, 6'(s), 4'(w))));
        look("R7 alias same line", 12'h020, 6'(s), 4'(w),
             exp_hit(s % 16, ew(1'b0, 12'h3A0, 6'(s), 4'(w))));
        look("R2 other page other way", 12'h030, 6'(s), 4'(w),
             exp_hit((s + 5) % 16, ew(1'b0, 12'h155, 6'(s), 4'(w))));
      end
    end

    // R5: a stale zero tag must not hit on a translation miss
    line_fill(6'd0, 4'd9, 12'h000, 1'b0);
    look("R5 miss suppresses hit", 12'hABC, 6'd0, 4'd1, EXP_TLBM);
    look("R5 unmapped page", 12'h999, 6'd17, 4'd7, EXP_TLBM);

    // R10: mapped page, no tag match
    look("R10 cache miss", 12'h050, 6'd3, 4'd4, EXP_MISS);

    // R11: overwrite set 3 way 8 with a new tag and new data
    line_fill(6'd3, 4'd8, 12'h777, 1'b1);
    look("R11 old tag gone", 12'h030, 6'd3, 4'd4, EXP_MISS);
    look("R11 new tag and data", 12'h050, 6'd3, 4'd4, exp_hit(8, ew(1'b1, 12'h777, 6'd3, 4'd4)));
    look("R11 other sets intact", 12'h030, 6'd4, 4'd4, exp_hit(9, ew(1'b0, 12'h155, 6'd4, 4'd4)));

    // R8: fill slots 4..15, then the next new page wraps to slot 0
    for (int i = 0; i < 12; i++) tlb_fill(12'h100 + 12'(i), 12'h200 + 12'(i));
    look("R8 slot 15 live", 12'h10B, 6'd2, 4'd0, EXP_MISS);
    tlb_fill(12'h0F0, 12'h3A0);
    look("R8 oldest evicted", 12'h010, 6'd6, 4'd3, EXP_TLBM);
    look("R8 second entry kept", 12'h020, 6'd6, 4'd3, exp_hit(6, ew(1'b0, 12'h3A0, 6'd6, 4'd3)));
    look("R8 new entry", 12'h0F0, 6'd6, 4'd3, exp_hit(6, ew(1'b0, 12'h3A0, 6'd6, 4'd3)));

    // R9: refill existing page in place; pointer stays on slot 1
    tlb_fill(12'h020, 12'h155);
    look("R9 in-place update", 12'h020, 6'd7, 4'd9, exp_hit(12, ew(1'b0, 12'h155, 6'd7, 4'd9)));
    look("R9 no eviction", 12'h030, 6'd7, 4'd9, exp_hit(12, ew(1'b0, 12'h155, 6'd7, 4'd9)));
    tlb_fill(12'h0F1, 12'h3A0);
    look("R9 pointer held, slot 1 evicted", 12'h020, 6'd7, 4'd9, EXP_TLBM);
    look("R9 slot 2 kept", 12'h030, 6'd7, 4'd9, exp_hit(12, ew(1'b0, 12'h155, 6'd7, 4'd9)));
    look("R9 new page", 12'h0F1, 6'd7, 4'd9, exp_hit(7, ew(1'b0, 12'h3A0, 6'd7, 4'd9)));

    finish_run();
  end
endmodule